// File: doc/BRIEF.md
# SPI Command Queue and Command-Cycle Sequencer

This block holds up to four queued SPI commands and decides, for the command at the head of the queue, how many data frames it governs before it is retired. Each command word carries a select field that picks one of several attribute sets. The attribute sets are supplied as input buses. The selected set provides the frame size, as an extension bit plus a base size field, and a per-command frame count. The head command and its frame size are presented to the transmit path. The transmit path returns one pulse for every data frame it moves into its shift register.

There are two operating modes. With the extended mode off, every command is paired with exactly one data frame, so each frame pulse retires the head command. With the extended mode on, one command stays at the head for the programmed number of frames. A programmed count of zero means one frame. The block reports a busy flag, the number of queued commands and the index of the entry that the next command cycle will use. The busy flag is high while the current command still has more than its final frame to go. A flush input empties the queue and restarts the sequencing.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, the queue count is 0, the next-command index is 0, `busy_o` is 0 and `cur_valid_o` is 0.
- R2: A push while fewer than four commands are queued adds the command and raises the count by one. A push while four are queued is dropped, and that command never reaches the head.
- R3: `cur_cmd_o` shows the oldest queued command, and `cur_valid_o` is 1 exactly when the count is nonzero.
- R4: With `ext_en_i` low, each `frame_i` pulse retires the head command. The count drops by one and the next-command index advances by one.
- R5: With `ext_en_i` high, the head command is retired on the Nth `frame_i` pulse of its cycle, where N is the count field of the attribute set selected by command bits [14:12]. The index does not move on the earlier pulses.
- R6: A count field of zero is treated as N = 1.
- R7: `busy_o` is 1 while a command is queued and the frame about to be sent is not the final frame of its cycle. It is 0 on the final frame and 0 while the queue is empty. With `ext_en_i` low, every frame is a final frame.
- R8: `cur_fsize_o` equals {extension bit, 4-bit size field} of the attribute set selected by command bits [14:12] of the head command.
- R9: The next-command index wraps from 3 to 0.
- R10: `flush_i` clears the count, the next-command index, the in-cycle frame counter and `busy_o`. A push or frame pulse in the same cycle as a flush is ignored.
- R11: A push together with a retiring frame pulse leaves the count unchanged and advances the index. A push together with a non-final frame pulse raises the count without moving the index.
- R12: A `frame_i` pulse while the queue is empty changes neither the count nor the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Enqueue `push_cmd_i` |
| push_cmd_i | input | 16 | Command word; bits [14:12] select the attribute set |
| flush_i | input | 1 | Empty the queue and restart sequencing |
| ext_en_i | input | 1 | Extended mode: one command governs several frames |
| frame_i | input | 1 | One data frame moved into the shift register |
| attr_size_i | input | 32 | Base size field, 4 bits per attribute set, set k at [4k+3:4k] |
| attr_ext_i | input | 8 | Size extension bit, one per attribute set |
| attr_nfr_i | input | 48 | Frames per command, 6 bits per attribute set, set k at [6k+5:6k] |
| cur_valid_o | output | 1 | A command is queued |
| cur_cmd_o | output | 16 | Head command word |
| cur_fsize_o | output | 5 | Frame size of the head command |
| busy_o | output | 1 | Current command has frames left beyond the next one |
| cmd_cnt_o | output | 3 | Number of queued commands |
| next_ptr_o | output | 2 | Entry index used by the next command cycle |

## Verification
Enqueuing and retiring a command can land in the same cycle. The bench provokes this by raising `push_i` together with `frame_i` in both modes, once on a retiring frame and once on a non-final extended-mode frame. It judges the result from the count, the index and the command that appears at the head afterwards. The bench also places a push in a flush cycle and a push into a full queue, and confirms that the dropped commands never surface.

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
  parameter int DEPTH   = 4,
  parameter int CMD_W   = 16,
  parameter int SEL_W   = 3,
  parameter int SEL_LSB = 12,
  parameter int FSZ_W   = 4,
  parameter int CNT_W   = 6,
  localparam int NSET   = 1 << SEL_W,
  localparam int PW     = $clog2(DEPTH),
  localparam int CTW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_i,
  input  logic [CMD_W-1:0]        push_cmd_i,
  input  logic                    flush_i,
  input  logic                    ext_en_i,
  input  logic                    frame_i,
  input  logic [NSET*FSZ_W-1:0]   attr_size_i,
  input  logic [NSET-1:0]         attr_ext_i,
  input  logic [NSET*CNT_W-1:0]   attr_nfr_i,
  output logic                    cur_valid_o,
  output logic [CMD_W-1:0]        cur_cmd_o,
  output logic [FSZ_W:0]          cur_fsize_o,
  output logic                    busy_o,
  output logic [CTW-1:0]          cmd_cnt_o,
  output logic [PW-1:0]           next_ptr_o
);

  logic [CMD_W-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_q;
  logic [CTW-1:0]   cnt_q;
  logic [CNT_W-1:0] fidx_q;

  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] nfr_raw, nfr;
  logic             has, full, last, wr, pop, adv;
  logic [PW-1:0]    wr_idx;

  assign cur_cmd_o = mem[rd_q];
  assign sel       = cur_cmd_o[SEL_LSB +: SEL_W];
  assign nfr_raw   = attr_nfr_i[int'(sel)*CNT_W +: CNT_W];
  assign nfr       = (nfr_raw == '0) ? CNT_W'(1) : nfr_raw;

  assign has    = cnt_q != '0;
  assign full   = cnt_q == CTW'(DEPTH);
  assign last   = !ext_en_i || ({1'b0, fidx_q} + 1'b1 >= {1'b0, nfr});
  assign wr     = push_i && !full && !flush_i;
  assign pop    = frame_i && has && last && !flush_i;
  assign adv    = frame_i && has && !last && !flush_i;
  assign wr_idx = rd_q + cnt_q[PW-1:0];

  assign cur_valid_o = has;
  assign cur_fsize_o = {attr_ext_i[sel], attr_size_i[int'(sel)*FSZ_W +: FSZ_W]};
  assign busy_o      = has && !last;
  assign cmd_cnt_o   = cnt_q;
  assign next_ptr_o  = rd_q;

  always_ff @(posedge clk) begin
    if (wr) mem[wr_idx] <= push_cmd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      fidx_q <= '0;
    end else if (flush_i) begin
      rd_q   <= '0;
      cnt_q  <= '0;
      fidx_q <= '0;
    end else begin
      cnt_q <= cnt_q + CTW'(wr) - CTW'(pop);
      if (pop) begin
        rd_q   <= rd_q + 1'b1;
        fidx_q <= '0;
      end else if (adv) begin
        fidx_q <= fidx_q + 1'b1;
      end
    end
  end

endmodule

module spi_cmd_seq_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_i,
  input logic                       flush_i,
  input logic                       ext_en_i,
  input logic                       frame_i,
  input logic                       busy_o,
  input logic [$clog2(DEPTH+1)-1:0] cmd_cnt_o,
  input logic [$clog2(DEPTH)-1:0]   next_ptr_o
);
  localparam int PW = $clog2(DEPTH);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cmd_cnt_o) <= DEPTH);

  // R4
  legacy_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en_i && frame_i && cmd_cnt_o != 0 && !flush_i)
    |=> next_ptr_o == $past(next_ptr_o) + PW'(1));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && frame_i && !flush_i) |=> $stable(next_ptr_o));

  // R7
  busy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt_o == 0 |-> !busy_o);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cmd_cnt_o == 0 && next_ptr_o == 0 && !busy_o));

  // R11
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && frame_i && !busy_o && !flush_i && cmd_cnt_o != 0 && int'(cmd_cnt_o) < DEPTH)
    |=> cmd_cnt_o == $past(cmd_cnt_o));

  // R12
  empty_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && cmd_cnt_o == 0 && !push_i) |=> (cmd_cnt_o == 0 && $stable(next_ptr_o)));
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .flush_i(flush_i),
  .ext_en_i(ext_en_i), .frame_i(frame_i), .busy_o(busy_o),
  .cmd_cnt_o(cmd_cnt_o), .next_ptr_o(next_ptr_o)
);

// File: tb/sim_spi_cmd_seq.sv
module sim_spi_cmd_seq;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        push_i = 0, flush_i = 0, ext_en_i = 0, frame_i = 0;
  logic [15:0] push_cmd_i = 0;
  logic [31:0] attr_size_i;
  logic [7:0]  attr_ext_i;
  logic [47:0] attr_nfr_i;
  logic        cur_valid_o, busy_o;
  logic [15:0] cur_cmd_o;
  logic [4:0]  cur_fsize_o;
  logic [2:0]  cmd_cnt_o;
  logic [1:0]  next_ptr_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_seq u0 (.*);

  function automatic logic [15:0] mk(int sel, int tag);
    return 16'((sel << 12) | tag);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit p, logic [15:0] c, bit f, bit fl);
    @(negedge clk);
    push_i = p; push_cmd_i = c; frame_i = f; flush_i = fl;
    @(posedge clk); #1;
    push_i = 0; frame_i = 0; flush_i = 0;
  endtask

  task automatic t_reset;
    chk("R1", "count", cmd_cnt_o, 0);
    chk("R1", "ptr", next_ptr_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "valid", cur_valid_o, 0);
  endtask

  task automatic t_legacy;
    ext_en_i = 0;
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 5; i++) cyc(1, mk(0, 16'hA0 + i), 0, 0);
    chk("R2", "count when full", cmd_cnt_o, 4);
    chk("R3", "head", cur_cmd_o, mk(0, 16'hA0));
    chk("R7", "legacy busy", busy_o, 0);
    cyc(0, 0, 1, 0);
    chk("R4", "ptr", next_ptr_o, 1);
    chk("R4", "count", cmd_cnt_o, 3);
    chk("R3", "head after pop", cur_cmd_o, mk(0, 16'hA1));
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R2", "last kept head", cur_cmd_o, mk(0, 16'hA3));
    cyc(0, 0, 1, 0);
    chk("R9", "ptr wrap", next_ptr_o, 0);
    chk("R3", "valid empty", cur_valid_o, 0);
    chk("R2", "dropped never queued", cmd_cnt_o, 0);
    cyc(0, 0, 1, 0);
    chk("R12", "count empty frame", cmd_cnt_o, 0);
    chk("R12", "ptr empty frame", next_ptr_o, 0);
  endtask

  task automatic t_ext;
    cyc(0, 0, 0, 1);
    ext_en_i = 1;
    cyc(1, mk(0, 1), 0, 0);
    cyc(1, mk(1, 2), 0, 0);
    cyc(1, mk(5, 3), 0, 0);
    chk("R8", "fsize set0", cur_fsize_o, 7);
    chk("R7", "busy first", busy_o, 1);
    cyc(0, 0, 1, 0);
    chk("R5", "ptr held 1", next_ptr_o, 0);
    chk("R7", "busy mid", busy_o, 1);
    cyc(0, 0, 1, 0);
    chk("R5", "ptr held 2", next_ptr_o, 0);
    chk("R7", "busy final", busy_o, 0);
    cyc(0, 0, 1, 0);
    chk("R5", "ptr after N", next_ptr_o, 1);
    chk("R5", "count", cmd_cnt_o, 2);
    chk("R8", "fsize set1", cur_fsize_o, 19);
    chk("R6", "busy zero count", busy_o, 0);
    cyc(0, 0, 1, 0);
    chk("R6", "ptr after one", next_ptr_o, 2);
    chk("R8", "fsize set5", cur_fsize_o, 31);
    chk("R7", "busy set5", busy_o, 1);
    cyc(0, 0, 1, 0);
    chk("R5", "ptr set5 held", next_ptr_o, 2);
    cyc(0, 0, 1, 0);
    chk("R5", "ptr set5 done", next_ptr_o, 3);
    chk("R7", "busy empty", busy_o, 0);
  endtask

  task automatic t_flush;
    ext_en_i = 1;
    cyc(1, mk(0, 4), 0, 0);
    cyc(1, mk(0, 5), 0, 0);
    cyc(0, 0, 1, 0);
    cyc(1, mk(0, 6), 1, 1);
    chk("R10", "count", cmd_cnt_o, 0);
    chk("R10", "ptr", next_ptr_o, 0);
    chk("R10", "busy", busy_o, 0);
    cyc(1, mk(0, 7), 0, 0);
    chk("R10", "head after flush", cur_cmd_o, mk(0, 7));
    chk("R10", "count after flush", cmd_cnt_o, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R10", "frame counter cleared", next_ptr_o, 0);
    cyc(0, 0, 1, 0);
    chk("R10", "third frame retires", next_ptr_o, 1);
  endtask

  task automatic t_both;
    ext_en_i = 0;
    cyc(0, 0, 0, 1);
    cyc(1, mk(2, 8), 0, 0);
    cyc(1, mk(2, 9), 1, 0);
    chk("R11", "count same", cmd_cnt_o, 1);
    chk("R11", "ptr adv", next_ptr_o, 1);
    chk("R11", "head new", cur_cmd_o, mk(2, 9));
    ext_en_i = 1;
    cyc(0, 0, 1, 0);
    cyc(1, mk(0, 10), 0, 0);
    cyc(1, mk(0, 11), 1, 0);
    chk("R11", "count up mid", cmd_cnt_o, 2);
    chk("R11", "ptr held mid", next_ptr_o, 2);
  endtask

  initial begin
    attr_size_i = '0; attr_ext_i = '0; attr_nfr_i = '0;
    for (int k = 0; k < 8; k++) attr_nfr_i[k*6 +: 6] = 6'd1;
    attr_size_i[0*4 +: 4] = 4'd7;  attr_nfr_i[0*6 +: 6] = 6'd3;
    attr_size_i[1*4 +: 4] = 4'd3;  attr_ext_i[1] = 1; attr_nfr_i[1*6 +: 6] = 6'd0;
    attr_size_i[5*4 +: 4] = 4'd15; attr_ext_i[5] = 1; attr_nfr_i[5*6 +: 6] = 6'd2;
    repeat (3) @(posedge clk);
    #1 t_reset;
    @(negedge clk) rst_n = 1;
    t_legacy;
    t_ext;
    t_flush;
    t_both;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule